// File: doc/BRIEF.md
# External Memory Cycle Generator

This block drives byte-wide accesses on an external memory bus of the classic 8-bit style: a 19-bit address, an 8-bit data bus with a separate output enable, and three active-low strobes (memory request, read, write). A command port starts one of four operations: a single read, a single write, a fill run that writes one byte value to consecutive addresses, and a streaming block write that takes each byte from a valid/ready input. The block takes a command only while an input says the bus currently belongs to it. Arbitration for the bus, processor reset control and wait states are handled elsewhere.

Every strobe phase has a fixed length in clocks, set by parameters: a setup phase with the address (and, for writes, the data) on the bus before the strobe falls, the strobe-low phase, and one clock of hold with the strobe high before the request strobe rises or the next byte starts. In both run modes the request strobe stays low across all bytes and only the write strobe pulses per byte. A one-clock `done_o` pulse marks the end of every accepted command.

Top module: `ext_mem_cycler`

## Requirements
- R1: After reset, mreq_n_o, rd_n_o and wr_n_o are high, mem_doe_o is low, done_o is low, and cmd_ready_o follows bus_owned_i.
- R2: cmd_ready_o is high only while the block is idle and bus_owned_i is high; a cmd_valid_i while bus_owned_i is low starts no strobe and produces no done_o.
- R3: Op code 1 (single write): MREQ falls with the address and data driven and mem_doe_o high, WR falls 2 clocks later and stays low 2 clocks with address and data unchanged, MREQ rises one clock after WR rises, and done_o is high in the 6th cycle after the accepting edge.
- R4: Op code 0 (single read): MREQ falls with the bus released (mem_doe_o low), RD falls 2 clocks later and stays low 3 clocks, rd_data_o takes mem_din_i as seen at the last clock edge with RD low, and done_o is high in the 7th cycle after the accepting edge.
- R5: Op code 2 (fill) with length N>0 writes cmd_data_i to N consecutive addresses from cmd_addr_i, with one MREQ low period for the whole run, a 2-clock WR pulse per byte and 5 clocks per byte; done_o is high in cycle 5N+1 after the accepting edge.
- R6: Op code 3 (stream) with length N>0 performs N write pulses to consecutive addresses, each using exactly one stream byte in arrival order; strm_ready_o is high only while the run waits for its next byte, and with the stream always valid done_o is high in cycle 6N+1.
- R7: Fill or stream with length 0 asserts no strobe and raises done_o in the first cycle after the accepting edge.
- R8: Run addresses increment modulo 2^19 (0x7FFFF is followed by 0x00000).
- R9: RD and WR are never low together nor while MREQ is high; in the done_o cycle all strobes are high and mem_doe_o is low.
- R10: Single read and write ignore cmd_len_i; a single write with length 0 still performs one write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_owned_i | input | 1 | High while the external bus is granted to this block |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command accepted on a clock edge where valid and ready are high |
| cmd_op_i | input | 2 | 0 read, 1 write, 2 fill, 3 stream |
| cmd_addr_i | input | 19 | Access or start address |
| cmd_data_i | input | 8 | Write or fill byte |
| cmd_len_i | input | 32 | Byte count for fill and stream |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Byte captured by the last read |
| strm_valid_i | input | 1 | Stream byte available |
| strm_ready_o | output | 1 | Stream byte taken on this edge when valid |
| strm_data_i | input | 8 | Stream byte |
| mem_addr_o | output | 19 | External address |
| mem_dout_o | output | 8 | Data driven onto the external bus |
| mem_din_i | input | 8 | Data read from the external bus |
| mem_doe_o | output | 1 | High to drive the data bus |
| mreq_n_o | output | 1 | Memory request strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
All outputs are registered, so a single write finishes on the 5th edge after acceptance, a read on the 6th, a fill of N bytes on edge 5N and a stream of N always-valid bytes on edge 6N, while a zero-length run reports on the accepting edge itself. The bench drives commands half a clock away from the active edge, counts falling edges from the acceptance until it sees done_o, and compares that count against these figures. A monitor sampling on the falling edge measures every strobe width and the number of stable setup clocks before each write pulse, and captures address and data at each write fall for comparison with arithmetically generated expectations.

// File: rtl/emc_pkg.sv
package emc_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_FILL   = 2'd2,
        OP_STREAM = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_SETUP,
        PH_STROBE,
        PH_GAP
    } phase_e;

    function automatic int imax3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/emc_phase_timer.sv
module emc_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/emc_addr_gen.sv
module emc_addr_gen #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o
);

    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load_i) begin
            addr_d = load_addr_i;
        end else if (step_i) begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/emc_len_ctr.sv
module emc_len_ctr #(
    parameter int LW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [LW-1:0] load_len_i,
    input  logic          dec_i,
    output logic          last_o
);

    logic [LW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load_i) begin
            left_d = load_len_i;
        end else if (dec_i && left_q != '0) begin
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign last_o = (left_q <= LW'(1));

endmodule

// File: rtl/ext_mem_cycler.sv
module ext_mem_cycler
    import emc_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int LW         = 32,
    parameter int SETUP_CLKS = 2,
    parameter int WR_CLKS    = 2,
    parameter int RD_CLKS    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_owned_i,
    input  logic          cmd_valid_i,
    output logic          cmd_ready_o,
    input  logic [1:0]    cmd_op_i,
    input  logic [AW-1:0] cmd_addr_i,
    input  logic [DW-1:0] cmd_data_i,
    input  logic [LW-1:0] cmd_len_i,
    output logic          done_o,
    output logic [DW-1:0] rd_data_o,
    input  logic          strm_valid_i,
    output logic          strm_ready_o,
    input  logic [DW-1:0] strm_data_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_dout_o,
    input  logic [DW-1:0] mem_din_i,
    output logic          mem_doe_o,
    output logic          mreq_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o
);

    localparam int TMAX = imax3(SETUP_CLKS, WR_CLKS, RD_CLKS);
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CLKS - 1);
    localparam logic [CW-1:0] WR_LD    = CW'(WR_CLKS - 1);
    localparam logic [CW-1:0] RD_LD    = CW'(RD_CLKS - 1);

    typedef struct packed {
        phase_e        phase;
        op_e           op;
        logic          mreq_n;
        logic          rd_n;
        logic          wr_n;
        logic          doe;
        logic [DW-1:0] dout;
        logic [DW-1:0] rd_data;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          addr_load;
    logic          addr_step;
    logic          len_load;
    logic [LW-1:0] len_val;
    logic          len_dec;
    logic          len_last;
    logic          accept;
    op_e           cmd_op;
    logic          cmd_is_run;

    assign cmd_op      = op_e'(cmd_op_i);
    assign cmd_is_run  = (cmd_op == OP_FILL) || (cmd_op == OP_STREAM);
    assign cmd_ready_o = (s_q.phase == PH_IDLE) && bus_owned_i;
    assign accept      = cmd_valid_i && cmd_ready_o;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = SETUP_LD;
        addr_load = 1'b0;
        addr_step = 1'b0;
        len_load  = 1'b0;
        len_val   = cmd_is_run ? cmd_len_i : LW'(1);
        len_dec   = 1'b0;

        case (s_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    s_d.op    = cmd_op;
                    addr_load = 1'b1;
                    len_load  = 1'b1;
                    if (cmd_is_run && cmd_len_i == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.mreq_n = 1'b0;
                        s_d.doe    = (cmd_op != OP_READ);
                        s_d.dout   = cmd_data_i;
                        if (cmd_op == OP_STREAM) begin
                            s_d.phase = PH_FETCH;
                        end else begin
                            s_d.phase = PH_SETUP;
                            tmr_load  = 1'b1;
                            tmr_val   = SETUP_LD;
                        end
                    end
                end
            end

            PH_FETCH: begin
                if (strm_valid_i) begin
                    s_d.dout  = strm_data_i;
                    s_d.phase = PH_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = SETUP_LD;
                end
            end

            PH_SETUP: begin
                if (tmr_expired) begin
                    s_d.phase = PH_STROBE;
                    tmr_load  = 1'b1;
                    if (s_q.op == OP_READ) begin
                        s_d.rd_n = 1'b0;
                        tmr_val  = RD_LD;
                    end else begin
                        s_d.wr_n = 1'b0;
                        tmr_val  = WR_LD;
                    end
                end
            end

            PH_STROBE: begin
                if (tmr_expired) begin
                    s_d.rd_n  = 1'b1;
                    s_d.wr_n  = 1'b1;
                    s_d.phase = PH_GAP;
                    if (s_q.op == OP_READ) begin
                        s_d.rd_data = mem_din_i;
                    end
                end
            end

            PH_GAP: begin
                if (len_last) begin
                    s_d.phase  = PH_IDLE;
                    s_d.mreq_n = 1'b1;
                    s_d.doe    = 1'b0;
                    s_d.done   = 1'b1;
                end else begin
                    addr_step = 1'b1;
                    len_dec   = 1'b1;
                    if (s_q.op == OP_STREAM) begin
                        s_d.phase = PH_FETCH;
                    end else begin
                        s_d.phase = PH_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = SETUP_LD;
                    end
                end
            end

            default: begin
                s_d.phase  = PH_IDLE;
                s_d.mreq_n = 1'b1;
                s_d.rd_n   = 1'b1;
                s_d.wr_n   = 1'b1;
                s_d.doe    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase   <= PH_IDLE;
            s_q.op      <= OP_READ;
            s_q.mreq_n  <= 1'b1;
            s_q.rd_n    <= 1'b1;
            s_q.wr_n    <= 1'b1;
            s_q.doe     <= 1'b0;
            s_q.dout    <= '0;
            s_q.rd_data <= '0;
            s_q.done    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    emc_phase_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    emc_addr_gen #(.AW(AW)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (addr_load),
        .load_addr_i (cmd_addr_i),
        .step_i      (addr_step),
        .addr_o      (mem_addr_o)
    );

    emc_len_ctr #(.LW(LW)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (len_load),
        .load_len_i (len_val),
        .dec_i      (len_dec),
        .last_o     (len_last)
    );

    assign strm_ready_o = (s_q.phase == PH_FETCH);
    assign done_o       = s_q.done;
    assign rd_data_o    = s_q.rd_data;
    assign mem_dout_o   = s_q.dout;
    assign mem_doe_o    = s_q.doe;
    assign mreq_n_o     = s_q.mreq_n;
    assign rd_n_o       = s_q.rd_n;
    assign wr_n_o       = s_q.wr_n;

endmodule

// File: rtl/ext_mem_cycler_chk.sv
module ext_mem_cycler_chk #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_owned_i,
    input logic          cmd_ready_o,
    input logic          done_o,
    input logic          strm_ready_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_dout_o,
    input logic          mem_doe_o,
    input logic          mreq_n_o,
    input logic          rd_n_o,
    input logic          wr_n_o
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));

    // R9
    strobe_in_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) |-> !mreq_n_o);

    // R3
    wr_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> mem_doe_o);

    // R4
    rd_floats_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !mem_doe_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mreq_n_o && rd_n_o && wr_n_o && !mem_doe_o));

    // R2
    ready_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> bus_owned_i);

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o && $past(!wr_n_o)) |-> ($stable(mem_dout_o) && $stable(mem_addr_o)));

    // R6
    strm_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strm_ready_o |-> (!mreq_n_o && !cmd_ready_o && wr_n_o));

endmodule

bind ext_mem_cycler ext_mem_cycler_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_owned_i  (bus_owned_i),
    .cmd_ready_o  (cmd_ready_o),
    .done_o       (done_o),
    .strm_ready_o (strm_ready_o),
    .mem_addr_o   (mem_addr_o),
    .mem_dout_o   (mem_dout_o),
    .mem_doe_o    (mem_doe_o),
    .mreq_n_o     (mreq_n_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o)
);

// File: tb/ext_mem_cycler_test.sv
`timescale 1ns/1ps
module ext_mem_cycler_test;

    localparam int AW = 19;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_owned_i = 1'b1;
    logic          cmd_valid_i = 1'b0;
    logic          cmd_ready_o;
    logic [1:0]    cmd_op_i = 2'd0;
    logic [AW-1:0] cmd_addr_i = '0;
    logic [DW-1:0] cmd_data_i = '0;
    logic [31:0]   cmd_len_i = '0;
    logic          done_o;
    logic [DW-1:0] rd_data_o;
    logic          strm_valid_i = 1'b0;
    logic          strm_ready_o;
    logic [DW-1:0] strm_data_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_dout_o;
    logic [DW-1:0] mem_din_i;
    logic          mem_doe_o;
    logic          mreq_n_o;
    logic          rd_n_o;
    logic          wr_n_o;

    always #2 clk = ~clk;

    // external memory content is a function of the address
    assign mem_din_i = rd_n_o ? 8'h00 : 8'(mem_addr_o[7:0] * 8'd7 + 8'd3);

    ext_mem_cycler uut (
        .clk(clk), .rst_n(rst_n), .bus_owned_i(bus_owned_i),
        .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_op_i(cmd_op_i),
        .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i), .cmd_len_i(cmd_len_i),
        .done_o(done_o), .rd_data_o(rd_data_o),
        .strm_valid_i(strm_valid_i), .strm_ready_o(strm_ready_o), .strm_data_i(strm_data_i),
        .mem_addr_o(mem_addr_o), .mem_dout_o(mem_dout_o), .mem_din_i(mem_din_i),
        .mem_doe_o(mem_doe_o), .mreq_n_o(mreq_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o)
    );

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_all();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // bus monitor, samples on the falling edge
    logic [AW-1:0] cap_addr [32];
    logic [DW-1:0] cap_data [32];
    int cap_n = 0, rd_cnt = 0, mreq_falls = 0, done_cnt = 0;
    logic [AW-1:0] rd_addr = '0;
    int wl = 0, rl = 0, st = 0;
    logic p_wr = 1'b1, p_rd = 1'b1, p_mreq = 1'b1;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dout = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_wr && !wr_n_o) begin
                chk(st == 2, "R3 stable setup clocks before WR", st, 2);
                chk(mem_doe_o && !mreq_n_o, "R3 bus driven under MREQ at WR", {mem_doe_o, mreq_n_o}, 2'b10);
                if (cap_n < 32) begin
                    cap_addr[cap_n] = mem_addr_o;
                    cap_data[cap_n] = mem_dout_o;
                end
                cap_n++;
                wl = 0;
            end
            if (!wr_n_o) wl++;
            if (!p_wr && wr_n_o) chk(wl == 2, "R3 WR low clocks", wl, 2);
            if (p_rd && !rd_n_o) begin
                rd_cnt++;
                rd_addr = mem_addr_o;
                rl = 0;
            end
            if (!rd_n_o) rl++;
            if (!p_rd && rd_n_o) chk(rl == 3, "R4 RD low clocks", rl, 3);
            if (p_mreq && !mreq_n_o) mreq_falls++;
            if (done_o) done_cnt++;
            if (!mreq_n_o && wr_n_o && rd_n_o && !p_mreq &&
                mem_addr_o == p_addr && mem_dout_o == p_dout) st++;
            else st = 1;
            p_wr = wr_n_o; p_rd = rd_n_o; p_mreq = mreq_n_o;
            p_addr = mem_addr_o; p_dout = mem_dout_o;
        end
    end

    // stream source
    logic [DW-1:0] sdat [16];
    int s_idx = 0, s_len = 0, s_gap = 0, s_cyc = 0;

    always @(negedge clk) begin
        #1;
        s_cyc++;
        strm_valid_i = (s_idx < s_len) && (s_gap == 0 || (s_cyc % s_gap) != 0);
        strm_data_i  = (s_idx < 16) ? sdat[s_idx] : 8'h00;
        if (strm_valid_i && strm_ready_o) s_idx++;
    end

    task automatic clear_mon();
        cap_n = 0; rd_cnt = 0; mreq_falls = 0; done_cnt = 0;
    endtask

    // issue one command, return cycles until done_o is seen
    task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [31:0] len,
                          input string tag, output int lat);
        @(negedge clk); #1;
        clear_mon();
        chk(cmd_ready_o, {tag, " ready before command"}, cmd_ready_o, 1);
        cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a; cmd_data_i = d; cmd_len_i = len;
        @(negedge clk); #1;
        cmd_valid_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 2000) begin
            @(negedge clk); #1;
            lat++;
        end
        chk(mreq_n_o && rd_n_o && wr_n_o && !mem_doe_o, "R9 idle bus at done",
            {mreq_n_o, rd_n_o, wr_n_o, mem_doe_o}, 4'b1110);
        @(negedge clk); #1;
        chk(!done_o, "R9 done is a single pulse", done_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
        finish_all();
    end

    initial begin
        int lat;
        for (int i = 0; i < 16; i++) sdat[i] = 8'(8'hA1 + i * 13);
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(mreq_n_o && rd_n_o && wr_n_o, "R1 strobes high in reset", {mreq_n_o, rd_n_o, wr_n_o}, 3'b111);
        chk(!mem_doe_o && !done_o, "R1 bus released in reset", {mem_doe_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cmd_ready_o, "R1 ready when owned", cmd_ready_o, 1);

        // R3 single writes (op 1)
        for (int i = 0; i < 4; i++) begin
            logic [AW-1:0] a = AW'(19'h12345 + i * 19'h11111);
            logic [DW-1:0] d = 8'(8'h3C + i * 41);
            do_cmd(2'd1, a, d, 32'd9, "R3", lat);
            chk(lat == 6, "R3 write latency", lat, 6);
            chk(cap_n == 1, "R3 one WR pulse", cap_n, 1);
            chk(cap_addr[0] == a && cap_data[0] == d, "R3 address/data at WR",
                {cap_addr[0], cap_data[0]}, {a, d});
        end

        // R10 single write with length 0 still writes
        do_cmd(2'd1, 19'h00777, 8'h5A, 32'd0, "R10", lat);
        chk(cap_n == 1, "R10 write ignores length", cap_n, 1);
        chk(lat == 6, "R10 write latency", lat, 6);

        // R4 single reads (op 0)
        for (int i = 0; i < 4; i++) begin
            logic [AW-1:0] a = AW'(19'h00010 + i * 19'h1F07);
            do_cmd(2'd0, a, 8'h00, (i == 0) ? 32'd0 : 32'd5, "R4", lat);
            chk(lat == 7, "R4 read latency", lat, 7);
            chk(rd_cnt == 1 && cap_n == 0, "R4 one RD pulse, no WR", rd_cnt * 16 + cap_n, 16);
            chk(rd_addr == a, "R4 read address", rd_addr, a);
            chk(rd_data_o == 8'(a[7:0] * 8'd7 + 8'd3), "R4 read data", rd_data_o,
                8'(a[7:0] * 8'd7 + 8'd3));
        end

        // R5 / R7 fill (op 2), lengths 0..5
        for (int n = 0; n < 6; n++) begin
            logic [AW-1:0] a = AW'(19'h40000 + n * 19'h100);
            logic [DW-1:0] d = 8'(8'h90 + n);
            do_cmd(2'd2, a, d, 32'(n), (n == 0) ? "R7" : "R5", lat);
            if (n == 0) begin
                chk(lat == 1, "R7 zero-length fill latency", lat, 1);
                chk(cap_n == 0 && rd_cnt == 0 && mreq_falls == 0, "R7 no strobe",
                    cap_n + rd_cnt + mreq_falls, 0);
            end else begin
                chk(lat == 5 * n + 1, "R5 fill latency", lat, 5 * n + 1);
                chk(cap_n == n, "R5 WR pulse count", cap_n, n);
                chk(mreq_falls == 1, "R5 single MREQ period", mreq_falls, 1);
                for (int k = 0; k < n; k++)
                    chk(cap_addr[k] == AW'(a + k) && cap_data[k] == d, "R5 fill address/data",
                        {cap_addr[k], cap_data[k]}, {AW'(a + k), d});
            end
        end

        // R8 wrap at the top of the address space
        do_cmd(2'd2, 19'h7FFFE, 8'hE7, 32'd3, "R8", lat);
        chk(cap_n == 3, "R8 wrap pulse count", cap_n, 3);
        chk(cap_addr[1] == 19'h7FFFF && cap_addr[2] == 19'h00000, "R8 address wraps",
            {cap_addr[1], cap_addr[2]}, {19'h7FFFF, 19'h00000});

        // R6 / R7 stream (op 3), several lengths and gap patterns
        for (int g = 0; g < 3; g++) begin
            for (int n = 0; n < 5; n++) begin
                logic [AW-1:0] a = AW'(19'h01230 + n * 19'h40 + g);
                s_idx = 0; s_len = n; s_gap = (g == 0) ? 0 : g + 1;
                do_cmd(2'd3, a, 8'h00, 32'(n), (n == 0) ? "R7" : "R6", lat);
                if (n == 0) begin
                    chk(lat == 1 && cap_n == 0 && mreq_falls == 0, "R7 zero-length stream",
                        lat * 100 + cap_n + mreq_falls, 100);
                end else begin
                    if (g == 0) chk(lat == 6 * n + 1, "R6 stream latency", lat, 6 * n + 1);
                    chk(cap_n == n && s_idx == n, "R6 one byte per WR pulse",
                        cap_n * 100 + s_idx, n * 101);
                    chk(mreq_falls == 1, "R6 single MREQ period", mreq_falls, 1);
                    for (int k = 0; k < n; k++)
                        chk(cap_addr[k] == AW'(a + k) && cap_data[k] == sdat[k],
                            "R6 stream address/data", {cap_addr[k], cap_data[k]},
                            {AW'(a + k), sdat[k]});
                end
            end
        end
        s_len = 0;

        // R2 command ignored while the bus is not owned
        @(negedge clk); #1;
        clear_mon();
        bus_owned_i = 1'b0;
        cmd_valid_i = 1'b1; cmd_op_i = 2'd1; cmd_addr_i = 19'h00042; cmd_len_i = 32'd1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            chk(!cmd_ready_o, "R2 not ready while not owned", cmd_ready_o, 0);
        end
        cmd_valid_i = 1'b0;
        bus_owned_i = 1'b1;
        repeat (8) @(negedge clk);
        #1;
        chk(cap_n == 0 && mreq_falls == 0 && done_cnt == 0, "R2 no access while not owned",
            cap_n + mreq_falls + done_cnt, 0);
        chk(cmd_ready_o, "R2 ready again when owned", cmd_ready_o, 1);

        finish_all();
    end

endmodule